// File: doc/BRIEF.md
# Fully Associative Translation Lookup Array

This block keeps a set of address-translation entries (64 by default) and searches all of them at once for a given virtual address and the current address-space identifier. Each entry describes a pair of adjacent virtual pages. It carries a region tag, the page-pair number, a per-entry page-size mask, an address-space identifier, a global flag and one payload per page of the pair. Each payload holds a frame number, a dirty bit, a page-valid bit and two capability-permission bits.

The search is purely combinational. It returns a hit flag, the index of the matching entry and a copy of that entry's contents. Entries are loaded through a single indexed write port and take effect from the following clock edge. Turning a hit into a physical address, choosing the even or odd page, raising exceptions and choosing a victim entry are left to the surrounding logic.

Top module: `tlb_assoc_lookup`

## Requirements
- R1: While `rst_n` is low every entry is invalidated, so after reset every lookup reports `lk_hit` = 0 until entries are written again.
- R2: When `wr_en` is high at a rising clock edge, all fields on the `wr_*` inputs are stored into entry `wr_idx`. A lookup sees the new contents only after that edge and never in the cycle the write is presented.
- R3: An entry whose valid bit is 0 never matches.
- R4: An entry matches only if its 2-bit region tag equals `lk_va[63:62]`.
- R5: The 27-bit page-pair number is compared against `lk_va[39:13]`. Bit k of the entry's 16-bit mask, when set, excludes bit k of both numbers from the comparison. Numbers bits 26..16 are always compared.
- R6: The identifier condition holds when the entry's 8-bit identifier equals `lk_asid` or the entry's global flag is set.
- R7: When several entries match, `lk_idx` reports the lowest matching index.
- R8: On a miss `lk_hit` is 0 and `lk_idx` and all entry outputs are 0.
- R9: On a hit the outputs carry the matched entry's stored region, page-pair number, mask, identifier, global flag and both page payloads unchanged. A payload is laid out as frame number in bits 27:4, dirty in bit 3, page-valid in bit 2, store-capability permission in bit 1 and load-capability permission in bit 0.
- R10: The lookup outputs follow changes of `lk_va` and `lk_asid` within the same cycle, with no clock edge needed.
- R11: Address bits 61:40 and 12:0 have no effect on the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Active-low asynchronous reset; invalidates all entries |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_region | input | 2 | Region tag to store |
| wr_vpn2 | input | 27 | Page-pair number to store |
| wr_mask | input | 16 | Page-size mask to store |
| wr_asid | input | 8 | Address-space identifier to store |
| wr_global | input | 1 | Global flag to store |
| wr_page0 | input | 28 | Even-page payload to store |
| wr_page1 | input | 28 | Odd-page payload to store |
| lk_va | input | 64 | Virtual address searched |
| lk_asid | input | 8 | Current address-space identifier |
| lk_hit | output | 1 | Some entry matched |
| lk_idx | output | 6 | Index of the lowest matching entry |
| lk_region | output | 2 | Matched entry region tag |
| lk_vpn2 | output | 27 | Matched entry page-pair number |
| lk_mask | output | 16 | Matched entry mask |
| lk_ent_asid | output | 8 | Matched entry identifier |
| lk_global | output | 1 | Matched entry global flag |
| lk_page0 | output | 28 | Matched entry even-page payload |
| lk_page1 | output | 28 | Matched entry odd-page payload |

## Verification
The search is driven with exact page-pair hits and with identifier mismatches. These show that the identifier is compared and that the global flag bypasses that comparison. Addresses differing only in the region field or only above a mask boundary separate the region check from the masked number check. Overlapping entries, one large-page and one small-page, show that the lowest index wins, and a valid entry placed behind an identical invalid one shows that the valid bit gates the match. Addresses carrying noise in the unused bit ranges show that those bits are ignored. A write presented while searching for its own key shows the one-edge visibility rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 64;
  localparam int REGION_W   = 2;
  localparam int VPN2_W     = 27;
  localparam int MASK_W     = 16;
  localparam int ASID_W     = 8;
  localparam int PFN_W      = 24;
  localparam int REGION_LSB = 62;
  localparam int VPN2_LSB   = 13;
  localparam int MASK_PAD_W = VPN2_W - MASK_W;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             dirty;
    logic             pvalid;
    logic             cap_st;
    logic             cap_ld;
  } tlb_page_t;

  localparam int PAGE_W = $bits(tlb_page_t);

  typedef struct packed {
    logic                valid;
    logic [REGION_W-1:0] region;
    logic [VPN2_W-1:0]   vpn2;
    logic [MASK_W-1:0]   mask;
    logic [ASID_W-1:0]   asid;
    logic                glob;
    tlb_page_t           page1;
    tlb_page_t           page0;
  } tlb_entry_t;

  // Bits of the page-pair number that take part in the comparison.
  function automatic logic [VPN2_W-1:0] keep_bits(input logic [MASK_W-1:0] m);
    return ~{{MASK_PAD_W{1'b0}}, m};
  endfunction

  // Full match rule of one entry against a search key.
  function automatic logic entry_hit(input tlb_entry_t e,
                                     input logic [REGION_W-1:0] region,
                                     input logic [VPN2_W-1:0] vpn2,
                                     input logic [ASID_W-1:0] asid);
    logic [VPN2_W-1:0] keep;
    keep = keep_bits(e.mask);
    return e.valid && (e.region == region) &&
           ((vpn2 & keep) == (e.vpn2 & keep)) &&
           ((e.asid == asid) || e.glob);
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  tlb_entry_t                   wr_data,
  output tlb_entry_t [NUM_ENTRIES-1:0] entries_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    tlb_entry_t ent_q;
    logic       sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (sel) begin
        ent_q <= wr_data;
      end
    end
    assign entries_o[g] = ent_q;
  end
endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64
) (
  input  tlb_entry_t [NUM_ENTRIES-1:0] entries_i,
  input  logic [REGION_W-1:0]          region_i,
  input  logic [VPN2_W-1:0]            vpn2_i,
  input  logic [ASID_W-1:0]            asid_i,
  output logic [NUM_ENTRIES-1:0]       match_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign match_o[g] = entry_hit(entries_i[g], region_i, vpn2_i, asid_i);
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int WIDTH = 64,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_assoc_lookup.sv
module tlb_assoc_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_valid,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [VPN2_W-1:0]   wr_vpn2,
  input  logic [MASK_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                wr_global,
  input  logic [PAGE_W-1:0]   wr_page0,
  input  logic [PAGE_W-1:0]   wr_page1,
  input  logic [VA_W-1:0]     lk_va,
  input  logic [ASID_W-1:0]   lk_asid,
  output logic                lk_hit,
  output logic [IDX_W-1:0]    lk_idx,
  output logic [REGION_W-1:0] lk_region,
  output logic [VPN2_W-1:0]   lk_vpn2,
  output logic [MASK_W-1:0]   lk_mask,
  output logic [ASID_W-1:0]   lk_ent_asid,
  output logic                lk_global,
  output logic [PAGE_W-1:0]   lk_page0,
  output logic [PAGE_W-1:0]   lk_page1
);
  tlb_entry_t                   wr_data;
  tlb_entry_t [NUM_ENTRIES-1:0] entries_q;
  logic [NUM_ENTRIES-1:0]       match_vec;
  logic [REGION_W-1:0]          key_region;
  logic [VPN2_W-1:0]            key_vpn2;
  logic                         unused_va_bits;
  tlb_entry_t                   sel_entry;

  assign wr_data = '{valid: wr_valid, region: wr_region, vpn2: wr_vpn2,
                     mask: wr_mask, asid: wr_asid, glob: wr_global,
                     page1: wr_page1, page0: wr_page0};

  assign key_region     = lk_va[REGION_LSB +: REGION_W];
  assign key_vpn2       = lk_va[VPN2_LSB +: VPN2_W];
  assign unused_va_bits = ^{lk_va[REGION_LSB-1:VPN2_LSB+VPN2_W], lk_va[VPN2_LSB-1:0]};

  tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .entries_o(entries_q)
  );

  tlb_match_unit #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .entries_i(entries_q),
    .region_i (key_region),
    .vpn2_i   (key_vpn2),
    .asid_i   (lk_asid),
    .match_o  (match_vec)
  );

  tlb_prio_enc #(.WIDTH(NUM_ENTRIES)) u_prio (
    .req_i  (match_vec),
    .found_o(lk_hit),
    .idx_o  (lk_idx)
  );

  always_comb begin
    sel_entry = '0;
    if (lk_hit) sel_entry = entries_q[lk_idx];
  end

  assign lk_region   = sel_entry.region;
  assign lk_vpn2     = sel_entry.vpn2;
  assign lk_mask     = sel_entry.mask;
  assign lk_ent_asid = sel_entry.asid;
  assign lk_global   = sel_entry.glob;
  assign lk_page0    = sel_entry.page0;
  assign lk_page1    = sel_entry.page1;
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [IDX_W-1:0]             wr_idx,
  input logic [VPN2_W-1:0]            wr_vpn2,
  input logic [ASID_W-1:0]            wr_asid,
  input logic [ASID_W-1:0]            lk_asid,
  input logic                         lk_hit,
  input logic [IDX_W-1:0]             lk_idx,
  input logic [VPN2_W-1:0]            lk_vpn2,
  input logic [NUM_ENTRIES-1:0]       match_vec,
  input tlb_entry_t [NUM_ENTRIES-1:0] entries_q
);
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entries_q[$past(wr_idx)].vpn2 == $past(wr_vpn2)) &&
              (entries_q[$past(wr_idx)].asid == $past(wr_asid)));

  // R3
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> entries_q[lk_idx].valid);

  // R6
  asid_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !entries_q[lk_idx].glob) |-> (entries_q[lk_idx].asid == lk_asid));

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (match_vec[lk_idx] &&
               ((match_vec & ((NUM_ENTRIES'(1) << lk_idx) - NUM_ENTRIES'(1))) == '0)));

  // R8
  miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (match_vec == '0) && (lk_idx == '0) && (lk_vpn2 == '0));

  // R9
  data_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_vpn2 == entries_q[lk_idx].vpn2));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (match_vec == '0));
endmodule

bind tlb_assoc_lookup tlb_lookup_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_vpn2  (wr_vpn2),
  .wr_asid  (wr_asid),
  .lk_asid  (lk_asid),
  .lk_hit   (lk_hit),
  .lk_idx   (lk_idx),
  .lk_vpn2  (lk_vpn2),
  .match_vec(match_vec),
  .entries_q(entries_q)
);

// File: tb/test_tlb_assoc_lookup.sv
module test_tlb_assoc_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_region = '0;
  logic [26:0] wr_vpn2 = '0;
  logic [15:0] wr_mask = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [27:0] wr_page0 = '0;
  logic [27:0] wr_page1 = '0;
  logic [63:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit;
  logic [5:0]  lk_idx;
  logic [1:0]  lk_region;
  logic [26:0] lk_vpn2;
  logic [15:0] lk_mask;
  logic [7:0]  lk_ent_asid;
  logic        lk_global;
  logic [27:0] lk_page0;
  logic [27:0] lk_page1;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc_lookup i_tlb_assoc_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_region(wr_region), .wr_vpn2(wr_vpn2),
    .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_page0(wr_page0), .wr_page1(wr_page1), .lk_va(lk_va),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_region(lk_region), .lk_vpn2(lk_vpn2), .lk_mask(lk_mask),
    .lk_ent_asid(lk_ent_asid), .lk_global(lk_global),
    .lk_page0(lk_page0), .lk_page1(lk_page1)
  );

  // Vector: {va[63:0], asid[7:0], exp_hit, exp_idx[5:0]}
  localparam logic [78:0] VECS [NV] = '{
    {2'd0, 22'd0, 27'h0000100, 13'd0, 8'd5,    1'b1, 6'd0},  // R5 exact
    {2'd0, 22'd0, 27'h0000100, 13'd0, 8'd6,    1'b0, 6'd0},  // R6 asid differs
    {2'd1, 22'd0, 27'h0000200, 13'd0, 8'h33,   1'b1, 6'd1},  // R6 global
    {2'd0, 22'd0, 27'h0000200, 13'd0, 8'd0,    1'b0, 6'd0},  // R4 region
    {2'd0, 22'd0, 27'h000100D, 13'd0, 8'd7,    1'b1, 6'd2},  // R5 masked
    {2'd0, 22'd0, 27'h0001005, 13'd0, 8'd7,    1'b1, 6'd2},  // R7 overlap
    {2'd0, 22'd0, 27'h0001015, 13'd0, 8'd7,    1'b0, 6'd0},  // R5 above mask
    {2'd2, 22'd0, 27'h0000300, 13'd0, 8'd9,    1'b1, 6'd5},  // R3 invalid skipped
    {2'd3, 22'd0, 27'h0000100, 13'd0, 8'd5,    1'b0, 6'd0},  // R4 region
    {2'd0, 22'h2A5A5A, 27'h0000100, 13'h1FFF, 8'd5, 1'b1, 6'd0} // R11 noise
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [5:0] idx, input logic v, input logic [1:0] rg,
                     input logic [26:0] vp, input logic [15:0] m, input logic [7:0] a,
                     input logic g, input logic [27:0] p0, input logic [27:0] p1);
    @(negedge clk);
    wr_idx = idx; wr_valid = v; wr_region = rg; wr_vpn2 = vp; wr_mask = m;
    wr_asid = a; wr_global = g; wr_page0 = p0; wr_page1 = p1; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [63:0] mkva(input logic [1:0] rg, input logic [26:0] vp);
    return {rg, 22'd0, vp, 13'd0};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state misses
    lk_va = mkva(2'd0, 27'h0); lk_asid = 8'd0;
    #1 check(lk_hit == 1'b0, "R1 reset miss", 64'(lk_hit), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    put(6'd0, 1'b1, 2'd0, 27'h0000100, 16'h0000, 8'd5, 1'b0, {24'hABCDE1, 4'b1010}, {24'h123456, 4'b0101});
    put(6'd1, 1'b1, 2'd1, 27'h0000200, 16'h0000, 8'd0, 1'b1, 28'h1, 28'h2);
    put(6'd2, 1'b1, 2'd0, 27'h0001000, 16'h000F, 8'd7, 1'b0, 28'h3, 28'h4);
    put(6'd3, 1'b1, 2'd0, 27'h0001005, 16'h0000, 8'd7, 1'b0, 28'h5, 28'h6);
    put(6'd4, 1'b0, 2'd2, 27'h0000300, 16'h0000, 8'd9, 1'b0, 28'h7, 28'h8);
    put(6'd5, 1'b1, 2'd2, 27'h0000300, 16'h0000, 8'd9, 1'b0, 28'h9, 28'hA);

    for (int k = 0; k < NV; k++) begin
      lk_va = VECS[k][78:15]; lk_asid = VECS[k][14:7];
      #1;
      check(lk_hit == VECS[k][6], $sformatf("R5/R6/R4 vec%0d hit", k), 64'(lk_hit), 64'(VECS[k][6]));
      check(lk_idx == VECS[k][5:0], $sformatf("R7/R3 vec%0d idx", k), 64'(lk_idx), 64'(VECS[k][5:0]));
      @(negedge clk);
    end

    // R9: full contents of entry 0
    lk_va = mkva(2'd0, 27'h0000100); lk_asid = 8'd5;
    #1;
    check(lk_page0 == {24'hABCDE1, 4'b1010}, "R9 page0", 64'(lk_page0), 64'({24'hABCDE1, 4'b1010}));
    check(lk_page1 == {24'h123456, 4'b0101}, "R9 page1", 64'(lk_page1), 64'({24'h123456, 4'b0101}));
    check(lk_vpn2 == 27'h100 && lk_ent_asid == 8'd5 && lk_region == 2'd0 && !lk_global && lk_mask == 16'h0,
          "R9 tag fields", 64'(lk_vpn2), 64'h100);
    // R10: same-cycle response to a new key
    lk_va = mkva(2'd1, 27'h0000200); lk_asid = 8'd77;
    #1;
    check(lk_hit && lk_idx == 6'd1 && lk_global, "R10 comb follow", 64'(lk_idx), 64'd1);
    // R8: miss leaves outputs zero
    lk_va = mkva(2'd3, 27'h7FFFFFF);
    #1;
    check(!lk_hit && lk_idx == 0 && lk_page0 == 0 && lk_page1 == 0 && lk_vpn2 == 0 && lk_mask == 0,
          "R8 miss zero", 64'(lk_page0), 64'd0);

    // R2: write visible only after the edge
    @(negedge clk);
    lk_va = mkva(2'd1, 27'h4444444); lk_asid = 8'd3;
    wr_idx = 6'd40; wr_valid = 1'b1; wr_region = 2'd1; wr_vpn2 = 27'h4444444;
    wr_mask = 16'h0; wr_asid = 8'd3; wr_global = 1'b0; wr_page0 = 28'hBEEF; wr_page1 = 28'h0;
    wr_en = 1'b1;
    #1 check(!lk_hit, "R2 before edge", 64'(lk_hit), 64'd0);
    @(negedge clk);
    wr_en = 1'b0;
    check(lk_hit && lk_idx == 6'd40 && lk_page0 == 28'hBEEF, "R2 after edge", 64'(lk_idx), 64'd40);
    // R5: largest mask ignores low 16 bits of the pair number
    put(6'd41, 1'b1, 2'd1, 27'h5550000, 16'hFFFF, 8'd3, 1'b0, 28'h0, 28'h0);
    lk_va = mkva(2'd1, 27'h555ABCD);
    #1 check(lk_hit && lk_idx == 6'd41, "R5 full mask", 64'(lk_idx), 64'd41);
    lk_va = mkva(2'd1, 27'h554ABCD);
    #1 check(!lk_hit, "R5 bit16 compared", 64'(lk_hit), 64'd0);

    // R1: reset again clears all written entries
    @(negedge clk);
    rst_n = 1'b0;
    lk_va = mkva(2'd0, 27'h0000100); lk_asid = 8'd5;
    #1 check(!lk_hit, "R1 reset clears", 64'(lk_hit), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!lk_hit, "R1 stays clear", 64'(lk_hit), 64'd0);

    done = 1;
    finish_run();
  end
endmodule